// File: doc/BRIEF.md
# Outer-Product Byte-Dot Accumulator with Interleaved Write-Back

This block keeps a square array of 32-bit running sums. Its side is N = VLEN / 32, the number of 32-bit words in one vector. An upstream stage fetches a column vector A and a row vector B from the register file and presents both on ports. It also presents a 9-bit bias for each side and a signedness flag for each side. An operation takes effect only in a cycle where both `op_valid` and `op_ready` are high.

An accumulate operation adds a byte dot product into every cell (i,j). Each of the four bytes of A word i and of B word j is first widened, as signed or unsigned according to its flag. The sign-extended 9-bit bias of that side is then added to it. The four pairwise products are summed.

A drain operation writes the array back as N full vectors on a write-back port, one cycle after the drain is accepted, and clears every sum. The cells are not read out in order. They are scattered by a fixed row-quad and word interleave into the register bank that starts at `DST_BASE`.

A small state machine sequences the write-back. In state IDLE the write-back port is quiet. An accepted drain causes the transition IDLE→EMIT. In EMIT the N vectors are presented for exactly one cycle. From EMIT, another accepted drain gives EMIT→EMIT; otherwise the machine takes EMIT→IDLE.

Top module: `opacc_top`

## Requirements
- R1: After reset all sums are zero, the machine is in IDLE and `wb_valid` is low; a drain issued right after reset writes back all-zero vectors.
- R2: An operation with `op_valid` or `op_ready` low has no effect: sums are kept and no write-back follows.
- R3: With both signedness flags low and zero biases, an accumulate adds to cell (i,j) the sum over byte lanes k=0..3 of A[i].byte[k] × B[j].byte[k], treating the bytes as unsigned. Word i occupies bits 32i+31..32i of `a_col` and `b_row`; byte k occupies bits 8k+7..8k of a word.
- R4: `a_signed` = 1 makes every A byte a two's-complement value; `b_signed` = 1 does the same for every B byte.
- R5: Each bias is a 9-bit two's-complement value. It is added to every byte of its side before the multiply. The 32-bit sum holds the result in two's complement.
- R6: Successive accepted accumulates add into the existing sums.
- R7: Drain mapping: cell (i,j) goes to write-back lane r = 4·⌊i/4⌋ + P[j mod 4], with P = {0,2,1,3}. It lands in word w = (i mod 4)·(N/4) + ⌊j/4⌋ of that lane, at bits 32w+31..32w. Lane r occupies bits VLEN·r+VLEN−1..VLEN·r of `wb_data`.
- R8: Exactly one cycle after an accepted drain, all N bits of `wb_valid` are high, with lane r's address equal to `DST_BASE` + r in bits 6r+5..6r of `wb_addr`. In any other cycle `wb_valid` is all zero.
- R9: Every sum is zero after a drain, so a following drain writes back zeros.
- R10: An accumulate and a drain accepted in the same cycle both act: the written-back values include that accumulation, and the array is zero afterwards.
- R11: Drains accepted on consecutive cycles keep `wb_valid` high on both following cycles, each with its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | input | 1 | Operation may be taken |
| op_accum | input | 1 | Accumulate the outer byte-dot product |
| op_drain | input | 1 | Write back and clear the array |
| a_col | input | VLEN | A operand, word i per row |
| b_row | input | VLEN | B operand, word j per column |
| a_bias | input | 9 | Signed bias added to A bytes |
| b_bias | input | 9 | Signed bias added to B bytes |
| a_signed | input | 1 | A bytes are signed |
| b_signed | input | 1 | B bytes are signed |
| wb_valid | output | N | Per-lane write-back valid |
| wb_addr | output | 6·N | Per-lane destination register |
| wb_data | output | VLEN·N | Per-lane full-vector data |

## Verification
Sums update at the clock edge that accepts an accumulate. Write-back data and valid appear one register stage after the edge that accepts a drain, and drop at the next edge unless another drain is accepted. The bench applies each operation away from the clock edge and samples the write-back port shortly after the very edge that accepted it. Every cycle is checked: a full comparison against the bench's own model when a drain was taken, and a quiet port otherwise. Accumulated state is observed only through later drains.

// File: rtl/opacc_pkg.sv
package opacc_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } opacc_state_e;

    // Word interleave inside a quad of lanes: self-inverse permutation.
    function automatic int quad_perm(input int x);
        case (x & 3)
            0:       return 0;
            1:       return 2;
            2:       return 1;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/opacc_dotp.sv
module opacc_dotp #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int BIAS_W = 9
) (
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [BIAS_W-1:0] a_bias,
    input  logic [BIAS_W-1:0] b_bias,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [WORD_W-1:0] dot
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int OPW   = BIAS_W + 2;
    localparam int PW    = 2 * OPW;

    logic [LANES-1:0][PW-1:0] prods;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [BYTE_W-1:0]     ab, bb;
        logic signed [OPW-1:0] oa, ob;
        logic signed [PW-1:0]  pr;
        assign ab = a_word[k*BYTE_W +: BYTE_W];
        assign bb = b_word[k*BYTE_W +: BYTE_W];
        assign oa = $signed({{(OPW-BYTE_W){a_signed & ab[BYTE_W-1]}}, ab})
                  + $signed({{(OPW-BIAS_W){a_bias[BIAS_W-1]}}, a_bias});
        assign ob = $signed({{(OPW-BYTE_W){b_signed & bb[BYTE_W-1]}}, bb})
                  + $signed({{(OPW-BIAS_W){b_bias[BIAS_W-1]}}, b_bias});
        assign pr = oa * ob;
        assign prods[k] = pr;
    end

    always_comb begin
        dot = '0;
        for (int k = 0; k < LANES; k++) begin
            dot = dot + {{(WORD_W-PW){prods[k][PW-1]}}, prods[k]};
        end
    end

    // Unsigned bytes with zero bias can never give a negative sum.
    always_comb begin
        if (!a_signed && !b_signed && a_bias == '0 && b_bias == '0) begin
            assert_unsigned_nonneg_R3: assert (dot[WORD_W-1] == 1'b0);
        end
    end
endmodule

// File: rtl/opacc_scatter.sv
module opacc_scatter #(
    parameter int N      = 4,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0][N-1:0][WORD_W-1:0] cells,
    output logic [N-1:0][N*WORD_W-1:0]      lanes
);
    import opacc_pkg::*;
    localparam int QW = N / 4;

    always_comb begin
        lanes = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                lanes[(i / 4) * 4 + quad_perm(j)][((i % 4) * QW + j / 4) * WORD_W +: WORD_W]
                    = cells[i][j];
            end
        end
    end
endmodule

// File: rtl/opacc_top.sv
module opacc_top #(
    parameter int VLEN     = 128,
    parameter int ADDR_W   = 6,
    parameter int DST_BASE = 48,
    parameter int BIAS_W   = 9,
    localparam int N       = VLEN / 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic                op_ready,
    input  logic                op_accum,
    input  logic                op_drain,
    input  logic [VLEN-1:0]     a_col,
    input  logic [VLEN-1:0]     b_row,
    input  logic [BIAS_W-1:0]   a_bias,
    input  logic [BIAS_W-1:0]   b_bias,
    input  logic                a_signed,
    input  logic                b_signed,
    output logic [N-1:0]        wb_valid,
    output logic [N*ADDR_W-1:0] wb_addr,
    output logic [N*VLEN-1:0]   wb_data
);
    import opacc_pkg::*;

    opacc_state_e st_q, st_d;
    logic [N-1:0][N-1:0][WORD_W-1:0] acc_q, sum_w, dot_w;
    logic [N-1:0][VLEN-1:0]          lanes_w, wb_q;
    logic accept, do_acc, do_drain;

    assign accept   = op_valid & op_ready;
    assign do_acc   = accept & op_accum;
    assign do_drain = accept & op_drain;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            opacc_dotp #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .BIAS_W(BIAS_W)) u_dot (
                .a_word  (a_col[i*WORD_W +: WORD_W]),
                .b_word  (b_row[j*WORD_W +: WORD_W]),
                .a_bias  (a_bias),
                .b_bias  (b_bias),
                .a_signed(a_signed),
                .b_signed(b_signed),
                .dot     (dot_w[i][j])
            );
            assign sum_w[i][j] = acc_q[i][j] + (do_acc ? dot_w[i][j] : '0);
        end
    end

    opacc_scatter #(.N(N), .WORD_W(WORD_W)) u_scatter (
        .cells(sum_w),
        .lanes(lanes_w)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = do_drain ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = do_drain ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Accumulator array and write-back data
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            wb_q  <= '0;
        end else begin
            acc_q <= do_drain ? '0 : sum_w;
            if (do_drain) wb_q <= lanes_w;
        end
    end

    // Outputs
    always_comb begin
        wb_valid = (st_q == ST_EMIT) ? {N{1'b1}} : '0;
        wb_data  = wb_q;
        wb_addr  = '0;
        for (int r = 0; r < N; r++) begin
            if (st_q == ST_EMIT) wb_addr[r*ADDR_W +: ADDR_W] = ADDR_W'(DST_BASE + r);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> wb_valid == '0);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_ready) |=> acc_q == $past(acc_q));
    assert_quiet_without_drain_R2: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_ready && op_drain) |=> wb_valid == '0);
    assert_emit_after_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_drain) |=> wb_valid == {N{1'b1}});
    assert_lanes_together_R8: assert property (@(posedge clk) disable iff (rst)
        ($countones(wb_valid) == 0) || ($countones(wb_valid) == N));
    assert_cleared_after_drain_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_drain) |=> acc_q == '0);
endmodule

// File: tb/tb_opacc_top.sv
module tb_opacc_top;
    localparam int VLEN = 128;
    localparam int N    = VLEN / 32;
    localparam int QW   = N / 4;
    localparam int BASE = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0, op_ready = 1'b0, op_accum = 1'b0, op_drain = 1'b0;
    logic [VLEN-1:0] a_col = '0, b_row = '0;
    logic [8:0] a_bias = '0, b_bias = '0;
    logic a_signed = 1'b0, b_signed = 1'b0;
    logic [N-1:0]      wb_valid;
    logic [N*6-1:0]    wb_addr;
    logic [N*VLEN-1:0] wb_data;

    int n_chk = 0, n_bad = 0;
    int macc [N][N];
    int snap [N][N];

    always #2 clk = ~clk;

    opacc_top #(.VLEN(VLEN)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_accum(op_accum), .op_drain(op_drain), .a_col(a_col), .b_row(b_row),
        .a_bias(a_bias), .b_bias(b_bias), .a_signed(a_signed), .b_signed(b_signed),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int perm(input int x);
        return (x == 1) ? 2 : (x == 2) ? 1 : x;
    endfunction

    function automatic int bdot(input logic [31:0] a, input logic [31:0] b,
                                input logic [8:0] ab, input logic [8:0] bb,
                                input bit sa, input bit sb);
        int s = 0;
        for (int k = 0; k < 4; k++) begin
            int x = sa ? int'($signed(a[8*k +: 8])) : int'(a[8*k +: 8]);
            int y = sb ? int'($signed(b[8*k +: 8])) : int'(b[8*k +: 8]);
            x += int'($signed(ab));
            y += int'($signed(bb));
            s += x * y;
        end
        return s;
    endfunction

    // Drive one cycle, update the model, then check the write-back port.
    task automatic step(input bit v, input bit rd, input bit ac, input bit dr, input string req);
        bit took;
        @(negedge clk);
        op_valid = v; op_ready = rd; op_accum = ac; op_drain = dr;
        @(posedge clk);
        took = v && rd;
        if (took && ac)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    macc[i][j] += bdot(a_col[32*i +: 32], b_row[32*j +: 32],
                                       a_bias, b_bias, a_signed, b_signed);
        if (took && dr)
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    snap[i][j] = macc[i][j];
                    macc[i][j] = 0;
                end
        #1;
        if (took && dr) begin
            check(wb_valid == {N{1'b1}}, {req, " R8 valid"}, longint'(wb_valid), longint'({N{1'b1}}));
            for (int r = 0; r < N; r++) begin
                check(wb_addr[6*r +: 6] == 6'(BASE + r), {req, " R8 addr"},
                      longint'(wb_addr[6*r +: 6]), longint'(BASE + r));
                for (int w = 0; w < N; w++) begin
                    int i = (r / 4) * 4 + w / QW;
                    int j = 4 * (w % QW) + perm(r % 4);
                    logic [31:0] got = wb_data[VLEN*r + 32*w +: 32];
                    check(got == 32'(snap[i][j]), {req, " R7 data"}, longint'(got), longint'(32'(snap[i][j])));
                end
            end
        end else begin
            check(wb_valid == '0, {req, " quiet"}, longint'(wb_valid), 0);
        end
        op_valid = 1'b0; op_ready = 1'b0; op_accum = 1'b0; op_drain = 1'b0;
    endtask

    task automatic load(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                        input logic [8:0] ab, input logic [8:0] bb, input bit sa, input bit sb);
        @(negedge clk);
        a_col = a; b_row = b; a_bias = ab; b_bias = bb; a_signed = sa; b_signed = sb;
    endtask

    task automatic t_reset;
        check(wb_valid == '0, "R1 valid after reset", longint'(wb_valid), 0);
        step(1, 1, 0, 1, "R1 drain of reset state");
        step(0, 0, 0, 0, "R8 single-cycle emit");
    endtask

    task automatic t_unsigned;
        load(128'h01020304_FF00FF00_80808080_00000007, 128'h05060708_FFFFFFFF_01010101_00000003, 0, 0, 0, 0);
        step(1, 1, 1, 0, "R3 accumulate");
        step(1, 1, 0, 1, "R3 drain");
    endtask

    task automatic t_signed_bias;
        load(128'hFF80017F_00000000_FEDCBA98_7F7F7F7F, 128'h80808080_12345678_FFFFFFFF_01FF01FF, 9'h1F0, 9'h011, 1, 0);
        step(1, 1, 1, 0, "R4 R5 signed A");
        load(128'h11223344_80FF7F01_00000000_C0C0C0C0, 128'hF0E0D0C0_0000FF00_7F800180_10203040, 9'h100, 9'h0FF, 0, 1);
        step(1, 1, 1, 0, "R4 R5 signed B");
        step(1, 1, 0, 1, "R5 drain");
    endtask

    task automatic t_handshake;
        load(128'h0F0F0F0F_01010101_22222222_33333333, 128'h44444444_55555555_66666666_77777777, 9'h003, 0, 0, 0);
        step(1, 1, 1, 0, "R6 first");
        step(1, 0, 1, 0, "R2 valid without ready");
        step(0, 1, 1, 1, "R2 ready without valid");
        step(1, 1, 1, 0, "R6 second");
        step(1, 1, 0, 1, "R2 R6 drain");
        step(1, 1, 0, 1, "R9 drain after drain");
    endtask

    task automatic t_same_cycle;
        load(128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 128'h13579BDF_2468ACE0_FFFF0000_0000FFFF, 9'h1FF, 9'h002, 1, 1);
        step(1, 1, 1, 0, "R10 prior");
        step(1, 1, 1, 1, "R10 accumulate with drain");
        step(1, 1, 0, 1, "R9 R10 zero after");
        step(0, 0, 0, 0, "R8 idle");
    endtask

    task automatic t_back_to_back;
        load(128'h00000001_00000002_00000003_00000004, 128'h01010101_02020202_03030303_04040404, 0, 0, 0, 0);
        step(1, 1, 1, 0, "R11 fill");
        step(1, 1, 1, 1, "R11 first drain");
        step(1, 1, 1, 1, "R11 second drain");
        step(1, 1, 0, 1, "R11 third drain");
        step(0, 0, 0, 0, "R11 back to idle");
    endtask

    initial begin
        #(200000 * 4);
        check(0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) macc[i][j] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_unsigned();
        t_signed_bias();
        t_handshake();
        t_same_cycle();
        t_back_to_back();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule